// File: doc/BRIEF.md
# Branch and Trap Condition Evaluator

This block is the purely combinational decision stage that a 32-bit RISC core consults for every conditional control-flow instruction. From the major opcode, the 5-bit sub-code carried in the second register field and the 6-bit function code, it works out which comparison the instruction asks for. It then applies that comparison to two register values, or to the first register and a sign-extended 16-bit immediate, or to the first register and zero. It reports whether a branch is taken, whether a trap fires, whether the instruction writes a link register, and whether it is a "likely" form whose delay slot is annulled when the branch falls through.

Three encoding spaces feed one shared comparator: register-register traps in the function table under major opcode 0x00, the register-immediate space under major opcode 0x01 (zero-compare branches, their linking and likely forms, and immediate traps), and the compare branches at major opcodes 0x04-0x07 and 0x14-0x17. An unlisted code inside these spaces raises an illegal-encoding flag. Target calculation, delay-slot handling and exception entry belong to the surrounding pipeline.

Top module: `brtrap_cond_eval`

## Requirements
- R1: With major opcode 0x00, function codes 0x30, 0x31, 0x32, 0x33, 0x34 and 0x36 raise trap_taken_o when src_a_i >= src_b_i signed, >= unsigned, < signed, < unsigned, == and != respectively.
- R2: With major opcode 0x01, sub-code 0x00 takes the branch when src_a_i is negative and sub-code 0x01 when it is zero or positive. Sub-codes 0x02 and 0x03 evaluate the same conditions with likely_o high.
- R3: With major opcode 0x01, sub-codes 0x08-0x0C and 0x0E apply the R1 conditions in the same order to src_a_i and the immediate. The immediate is sign-extended to 32 bits even for the unsigned compares 0x09 and 0x0B.
- R4: Sub-codes 0x10 and 0x11 are the less-than-zero and greater-or-equal-zero branches with link_req_o high whether or not the branch is taken. Sub-codes 0x12 and 0x13 add likely_o high.
- R5: Major opcodes 0x04 and 0x05 branch when src_a_i equals, or differs from, src_b_i. Opcodes 0x06 and 0x07 branch when src_a_i is <= 0 or > 0 signed, and src_b_i has no effect on them.
- R6: Major opcodes 0x14-0x17 evaluate the conditions of 0x04-0x07 with likely_o high, whatever the outcome.
- R7: An unlisted function code under opcode 0x00, or an unlisted sub-code under opcode 0x01, raises illegal_o and holds branch_taken_o, trap_taken_o, link_req_o and likely_o low.
- R8: Any other major opcode drives all five outputs low.
- R9: branch_taken_o and trap_taken_o are never high together, and a trap never raises likely_o or link_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Major opcode of the instruction |
| subcode_i | input | 5 | Register-immediate sub-code (second register field) |
| func_i | input | 6 | Function code of the function table |
| src_a_i | input | 32 | First register operand |
| src_b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Raw 16-bit immediate, sign-extended inside |
| branch_taken_o | output | 1 | Conditional branch is taken |
| trap_taken_o | output | 1 | Conditional trap fires |
| link_req_o | output | 1 | Instruction writes the link register |
| likely_o | output | 1 | Likely form: annul the delay slot if not taken |
| illegal_o | output | 1 | Encoding inside the handled spaces is not defined |

## Verification
The bench builds the block with its default widths, a 32-bit datapath and a 16-bit immediate. These put the signed/unsigned split at 0x8000_0000 and the immediate sign bit at 0x8000 within reach of a small operand pool. Drawing operands from zero, one, all-ones, the two extreme signed values and equal pairs makes the equality, sign and unsigned-wrap boundaries of every condition come up often, including immediates whose extension turns a small unsigned value into a huge one.

// File: rtl/bte_pkg.sv
package bte_pkg;

    // Major opcodes handled by the unit
    localparam logic [5:0] OP_FUNC    = 6'h00;
    localparam logic [5:0] OP_REGIMM  = 6'h01;

    // Function-table row holding the register-register traps (func[5:3])
    localparam logic [2:0] FN_TRAP_ROW = 3'b110;

    // Sub-code groups (subcode[4:3]) in the register-immediate space
    localparam logic [1:0] RI_ZBR   = 2'b00;
    localparam logic [1:0] RI_TRAP  = 2'b01;
    localparam logic [1:0] RI_LINK  = 2'b10;

    typedef enum logic [3:0] {
        CND_NONE,
        CND_EQ,
        CND_NE,
        CND_LEZ,
        CND_GTZ,
        CND_LTZ,
        CND_GEZ,
        CND_GES,
        CND_GEU,
        CND_LTS,
        CND_LTU
    } cond_e;

    typedef enum logic [1:0] {
        RHS_REG,
        RHS_IMM,
        RHS_ZERO
    } rhs_e;

    typedef struct packed {
        logic  in_space;
        logic  bad;
        logic  is_br;
        logic  is_trap;
        logic  link;
        logic  likely;
        rhs_e  rhs;
        cond_e cond;
    } dec_t;

    typedef struct packed {
        logic eq;
        logic lt_s;
        logic lt_u;
    } cmp_t;

    // Shared ordering of trap conditions in both trap spaces
    function automatic cond_e trap_cond(input logic [2:0] sel);
        case (sel)
            3'd0:    trap_cond = CND_GES;
            3'd1:    trap_cond = CND_GEU;
            3'd2:    trap_cond = CND_LTS;
            3'd3:    trap_cond = CND_LTU;
            3'd4:    trap_cond = CND_EQ;
            3'd6:    trap_cond = CND_NE;
            default: trap_cond = CND_NONE;
        endcase
    endfunction

    // Turns the three comparator flags into the requested condition
    function automatic logic eval_cond(input cond_e c, input cmp_t f);
        case (c)
            CND_EQ:  eval_cond = f.eq;
            CND_NE:  eval_cond = !f.eq;
            CND_LEZ: eval_cond = f.lt_s || f.eq;
            CND_GTZ: eval_cond = !(f.lt_s || f.eq);
            CND_LTZ: eval_cond = f.lt_s;
            CND_GEZ: eval_cond = !f.lt_s;
            CND_GES: eval_cond = !f.lt_s;
            CND_GEU: eval_cond = !f.lt_u;
            CND_LTS: eval_cond = f.lt_s;
            CND_LTU: eval_cond = f.lt_u;
            default: eval_cond = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bte_decode.sv
module bte_decode
    import bte_pkg::*;
#(
    parameter int OPC_W = 6,
    parameter int SUB_W = 5,
    parameter int FN_W  = 6
) (
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [SUB_W-1:0] subcode_i,
    input  logic [FN_W-1:0]  func_i,
    output dec_t             dec_o
);

    always_comb begin
        dec_o          = '0;
        dec_o.rhs      = RHS_REG;
        dec_o.cond     = CND_NONE;

        if (opcode_i == OP_FUNC) begin
            dec_o.in_space = 1'b1;
            if (func_i[5:3] == FN_TRAP_ROW && trap_cond(func_i[2:0]) != CND_NONE) begin
                dec_o.is_trap = 1'b1;
                dec_o.cond    = trap_cond(func_i[2:0]);
            end else begin
                dec_o.bad = 1'b1;
            end
        end else if (opcode_i == OP_REGIMM) begin
            dec_o.in_space = 1'b1;
            case (subcode_i[4:3])
                RI_ZBR, RI_LINK: begin
                    if (!subcode_i[2]) begin
                        dec_o.is_br  = 1'b1;
                        dec_o.rhs    = RHS_ZERO;
                        dec_o.cond   = subcode_i[0] ? CND_GEZ : CND_LTZ;
                        dec_o.likely = subcode_i[1];
                        dec_o.link   = (subcode_i[4:3] == RI_LINK);
                    end else begin
                        dec_o.bad = 1'b1;
                    end
                end
                RI_TRAP: begin
                    if (trap_cond(subcode_i[2:0]) != CND_NONE) begin
                        dec_o.is_trap = 1'b1;
                        dec_o.rhs     = RHS_IMM;
                        dec_o.cond    = trap_cond(subcode_i[2:0]);
                    end else begin
                        dec_o.bad = 1'b1;
                    end
                end
                default: dec_o.bad = 1'b1;
            endcase
        end else if (opcode_i[5] == 1'b0 && opcode_i[3:2] == 2'b01) begin
            // compare branches, bit 4 selects the likely form
            dec_o.in_space = 1'b1;
            dec_o.is_br    = 1'b1;
            dec_o.likely   = opcode_i[4];
            case (opcode_i[1:0])
                2'd0:    begin dec_o.cond = CND_EQ;  dec_o.rhs = RHS_REG;  end
                2'd1:    begin dec_o.cond = CND_NE;  dec_o.rhs = RHS_REG;  end
                2'd2:    begin dec_o.cond = CND_LEZ; dec_o.rhs = RHS_ZERO; end
                default: begin dec_o.cond = CND_GTZ; dec_o.rhs = RHS_ZERO; end
            endcase
        end
    end

endmodule

// File: rtl/bte_rhs_mux.sv
module bte_rhs_mux
    import bte_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] src_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  rhs_e              sel_i,
    output logic [DATA_W-1:0] rhs_o
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        end else begin : g_trunc
            assign imm_ext = imm_i[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        case (sel_i)
            RHS_IMM:  rhs_o = imm_ext;
            RHS_ZERO: rhs_o = '0;
            default:  rhs_o = src_b_i;
        endcase
    end

endmodule

// File: rtl/bte_compare.sv
module bte_compare
    import bte_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs_i,
    input  logic [DATA_W-1:0] rhs_i,
    output cmp_t              flags_o
);

    always_comb begin
        flags_o.eq   = (lhs_i == rhs_i);
        flags_o.lt_s = ($signed(lhs_i) < $signed(rhs_i));
        flags_o.lt_u = (lhs_i < rhs_i);
    end

endmodule

// File: rtl/brtrap_cond_eval.sv
module brtrap_cond_eval
    import bte_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [5:0]        opcode_i,
    input  logic [4:0]        subcode_i,
    input  logic [5:0]        func_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic              branch_taken_o,
    output logic              trap_taken_o,
    output logic              link_req_o,
    output logic              likely_o,
    output logic              illegal_o
);

    dec_t              dec;
    logic [DATA_W-1:0] rhs;
    cmp_t              flags;
    logic              hit;

    bte_decode u_dec (
        .opcode_i  (opcode_i),
        .subcode_i (subcode_i),
        .func_i    (func_i),
        .dec_o     (dec)
    );

    bte_rhs_mux #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_rhs (
        .src_b_i (src_b_i),
        .imm_i   (imm_i),
        .sel_i   (dec.rhs),
        .rhs_o   (rhs)
    );

    bte_compare #(.DATA_W(DATA_W)) u_cmp (
        .lhs_i   (src_a_i),
        .rhs_i   (rhs),
        .flags_o (flags)
    );

    always_comb begin
        hit            = eval_cond(dec.cond, flags);
        branch_taken_o = dec.is_br   && hit;
        trap_taken_o   = dec.is_trap && hit;
        link_req_o     = dec.link;
        likely_o       = dec.likely;
        illegal_o      = dec.bad;
    end

    // Output-level consistency checks
    always_comb begin
        assert_taken_excl_R9: assert (!(branch_taken_o && trap_taken_o))
            else $error("branch and trap both taken");
        assert_trap_plain_R9: assert (!trap_taken_o || (!likely_o && !link_req_o))
            else $error("trap with likely or link");
        assert_bad_quiet_R7: assert (!illegal_o ||
                (!branch_taken_o && !trap_taken_o && !link_req_o && !likely_o))
            else $error("illegal encoding produced an action");
        assert_link_space_R4: assert (!link_req_o || (opcode_i == OP_REGIMM && subcode_i[4]))
            else $error("link outside linking sub-codes");
        assert_outside_R8: assert (dec.in_space ||
                !(branch_taken_o || trap_taken_o || link_req_o || likely_o || illegal_o))
            else $error("output raised outside handled spaces");
    end

endmodule

// File: tb/sim_brtrap_cond_eval.sv
module sim_brtrap_cond_eval;

    logic        clk = 1'b0;
    logic [5:0]  opc;
    logic [4:0]  sub;
    logic [5:0]  fn;
    logic [31:0] a, b;
    logic [15:0] imm;
    logic        br, tr, lk, lz, bad;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    brtrap_cond_eval u0 (
        .opcode_i(opc), .subcode_i(sub), .func_i(fn),
        .src_a_i(a), .src_b_i(b), .imm_i(imm),
        .branch_taken_o(br), .trap_taken_o(tr), .link_req_o(lk),
        .likely_o(lz), .illegal_o(bad)
    );

    // Expected {branch, trap, link, likely, illegal} from the requirements
    function automatic logic [4:0] model(input logic [5:0] o, input logic [4:0] s,
                                         input logic [5:0] f, input logic [31:0] x,
                                         input logic [31:0] y, input logic [15:0] im);
        logic [31:0] ie;
        logic pb, pt, pl, pk, pi;
        ie = {{16{im[15]}}, im};
        pb = 0; pt = 0; pl = 0; pk = 0; pi = 0;
        if (o == 6'h00) begin
            case (f)
                6'h30: pt = $signed(x) >= $signed(y);
                6'h31: pt = x >= y;
                6'h32: pt = $signed(x) < $signed(y);
                6'h33: pt = x < y;
                6'h34: pt = x == y;
                6'h36: pt = x != y;
                default: pi = 1;
            endcase
        end else if (o == 6'h01) begin
            case (s)
                5'h00: pb = x[31];
                5'h01: pb = !x[31];
                5'h02: begin pb = x[31];  pk = 1; end
                5'h03: begin pb = !x[31]; pk = 1; end
                5'h08: pt = $signed(x) >= $signed(ie);
                5'h09: pt = x >= ie;
                5'h0A: pt = $signed(x) < $signed(ie);
                5'h0B: pt = x < ie;
                5'h0C: pt = x == ie;
                5'h0E: pt = x != ie;
                5'h10: begin pb = x[31];  pl = 1; end
                5'h11: begin pb = !x[31]; pl = 1; end
                5'h12: begin pb = x[31];  pl = 1; pk = 1; end
                5'h13: begin pb = !x[31]; pl = 1; pk = 1; end
                default: pi = 1;
            endcase
        end else begin
            case (o)
                6'h04, 6'h14: pb = x == y;
                6'h05, 6'h15: pb = x != y;
                6'h06, 6'h16: pb = x[31] || x == 0;
                6'h07, 6'h17: pb = !x[31] && x != 0;
                default: ;
            endcase
            pk = (o >= 6'h14 && o <= 6'h17);
        end
        return {pb, pt, pl, pk, pi};
    endfunction

    task automatic run(input string tag, input logic [5:0] o, input logic [4:0] s,
                       input logic [5:0] f, input logic [31:0] x, input logic [31:0] y,
                       input logic [15:0] im);
        logic [4:0] exp_v, got;
        @(negedge clk);
        opc = o; sub = s; fn = f; a = x; b = y; imm = im;
        #3;
        exp_v = model(o, s, f, x, y, im);
        got = {br, tr, lk, lz, bad};
        n_chk++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%h sub=%h fn=%h a=%h b=%h imm=%h got=%b exp=%b (br,trap,link,likely,illegal)",
                     tag, o, s, f, x, y, im, got, exp_v);
        end
    endtask

    // Directed check of one output set
    task automatic expect5(input string tag, input logic [5:0] o, input logic [4:0] s,
                           input logic [5:0] f, input logic [31:0] x, input logic [31:0] y,
                           input logic [15:0] im, input logic [4:0] want);
        @(negedge clk);
        opc = o; sub = s; fn = f; a = x; b = y; imm = im;
        #3;
        n_chk++;
        if ({br, tr, lk, lz, bad} !== want) begin
            n_fail++;
            $display("FAIL %s op=%h sub=%h fn=%h got=%b exp=%b", tag, o, s, f,
                     {br, tr, lk, lz, bad}, want);
        end
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 7)
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        opc = '0; sub = '0; fn = '0; a = '0; b = '0; imm = '0;
        void'($urandom(32'h5EED_0042));

        // idle inputs: opcode 0, function 0 is unlisted
        expect5("R7 idle", 6'h00, 5'h0, 6'h00, 0, 0, 0, 5'b00001);
        // R1
        expect5("R1 tlt signed", 6'h00, 5'h0, 6'h32, 32'hFFFF_FFFF, 32'h1, 0, 5'b01000);
        expect5("R1 tltu", 6'h00, 5'h0, 6'h33, 32'hFFFF_FFFF, 32'h1, 0, 5'b00000);
        expect5("R1 tne equal", 6'h00, 5'h0, 6'h36, 32'h55, 32'h55, 0, 5'b00000);
        // R2
        expect5("R2 ltz min", 6'h01, 5'h00, 6'h0, 32'h8000_0000, 0, 0, 5'b10000);
        expect5("R2 gez likely zero", 6'h01, 5'h03, 6'h0, 32'h0, 0, 0, 5'b10010);
        expect5("R2 ltz likely not taken", 6'h01, 5'h02, 6'h0, 32'h5, 0, 0, 5'b00010);
        // R3
        expect5("R3 tgeiu ext", 6'h01, 5'h09, 6'h0, 32'hFFFF_FFF0, 0, 16'hFFFF, 5'b00000);
        expect5("R3 tlti neg", 6'h01, 5'h0A, 6'h0, 32'hFFFF_FFFB, 0, 16'hFFFE, 5'b01000);
        expect5("R3 tltiu ext", 6'h01, 5'h0B, 6'h0, 32'h0000_1000, 0, 16'h8000, 5'b01000);
        // R4
        expect5("R4 link not taken", 6'h01, 5'h10, 6'h0, 32'h5, 0, 0, 5'b00100);
        expect5("R4 link likely taken", 6'h01, 5'h13, 6'h0, 32'h0, 0, 0, 5'b10110);
        // R5
        expect5("R5 beq equal", 6'h04, 5'h0, 6'h0, 32'hA5A5, 32'hA5A5, 0, 5'b10000);
        expect5("R5 lez ignores b", 6'h06, 5'h0, 6'h0, 32'h0, 32'hFFFF_FFFF, 0, 5'b10000);
        expect5("R5 gtz zero ignores b", 6'h07, 5'h0, 6'h0, 32'h0, 32'h1, 0, 5'b00000);
        // R6
        expect5("R6 bne likely", 6'h15, 5'h0, 6'h0, 32'h1, 32'h2, 0, 5'b10010);
        expect5("R6 gtz likely not taken", 6'h17, 5'h0, 6'h0, 32'h8000_0000, 0, 0, 5'b00010);
        // R7
        expect5("R7 fn 0x35", 6'h00, 5'h0, 6'h35, 32'h1, 32'h1, 0, 5'b00001);
        expect5("R7 sub 0x0D", 6'h01, 5'h0D, 6'h0, 32'h1, 32'h1, 16'h1, 5'b00001);
        expect5("R7 sub 0x14", 6'h01, 5'h14, 6'h0, 32'h8000_0000, 0, 0, 5'b00001);
        // R8
        expect5("R8 other opcode", 6'h08, 5'h10, 6'h34, 32'h0, 32'h0, 0, 5'b00000);

        // Random mix, R9 exclusivity covered by the comparison against the model
        for (int i = 0; i < 600; i++) begin
            logic [5:0] o, f;
            logic [4:0] s;
            logic [31:0] x, y;
            logic [15:0] im;
            string tag;
            s = 5'($urandom); f = 6'($urandom);
            x = pick(); y = ($urandom % 4 == 0) ? x : pick();
            im = 16'($urandom);
            if ($urandom % 4 == 0) begin
                im = ($urandom % 2) ? 16'h8000 : 16'h7FFF;
                if ($urandom % 2) x = {{16{im[15]}}, im};
            end
            case ($urandom % 4)
                0: begin o = 6'h00; if ($urandom % 4 != 0) f = {3'b110, 3'($urandom)};
                         tag = "R1/R7 random"; end
                1: begin o = 6'h01; tag = "R2/R3/R4/R7 random"; end
                2: begin o = {1'b0, 1'($urandom), 2'b01, 2'($urandom)};
                         tag = "R5/R6 random"; end
                default: begin o = 6'($urandom); tag = "R8/R9 random"; end
            endcase
            run(tag, o, s, f, x, y, im);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule